// File: doc/BRIEF.md
# Fixed-Hardware Power-Management Register Block

This block holds the fixed power-management registers that an operating system reaches through a small I/O window. The window carries two event groups, each a pair of status and enable registers. The first is a 16-bit group for the power button and timer overflow. The second is an 8-bit general-purpose group whose bit 0 reports a change in battery information. The window also holds a 16-bit control register with the ACPI-mode bit and a sleep-type field, a free-running power-management timer, a reset register and a mode-command port. Each access gives a byte offset and a byte count. The decoder honours only the width that each register defines.

Both status groups are ANDed with their enables and the results are ORed into one registered, level-sensitive interrupt. A sleep-type write that moves the stored state to 5 raises a one-cycle power-off request. A magic byte written to the reset register raises a one-cycle reset request. The platform drives single-cycle event inputs for the power button and for battery changes. A sticky flag tells the platform when software has acknowledged the last power-button event.

The timer advances at `TMR_HZ` ticks per second from a `CLK_HZ` clock, using a fractional phase accumulator. Its count is `TMR_WIDTH` bits wide.

Top module: `pm_fixed_regs`

## Requirements
- R1: After reset, every status, enable and control register, the stored sleep state and the timer are zero, and `sciLevel`, `powerOffReq`, `resetReq` and `btnHandled` are low.
- R2: The timer at offset 0x08 gains exactly TMR_HZ/CLK_HZ per clock on average and wraps at 2^TMR_WIDTH. It reads zero-extended, and only a 4-byte read returns it.
- R3: The PM1 status (0x00), PM1 enable (0x02) and control (0x04) registers take 2-byte accesses only. GPE status (0x20) and GPE enable (0x21) take 1-byte accesses only. A read of the wrong width returns 0xFFFFFFFF with `ioRdUnused` high, and a write of the wrong width changes nothing.
- R4: Status bits clear when written with one and are unaffected by zero. Enable bits are plain read/write. An event that arrives in the same cycle as a clearing write leaves its status bit set.
- R5: PM1 status bit 0 is set whenever the most significant bit of the timer count toggles.
- R6: `pwrBtnEvent` sets PM1 status bit 8 and clears `btnHandled`. A 2-byte status write with bit 8 set makes `btnHandled` high, and the flag stays high until the next event.
- R7: `sciLevel` follows, one clock later, the OR of two terms: any PM1 status bit with its enable bit set, and any GPE status bit with its enable bit set.
- R8: `batInfoEvent` sets GPE status bit 0.
- R9: The sleep-type field is control bits 12:10. A control write whose field differs from the stored state takes the new value, and it pulses `powerOffReq` for one cycle only when that value is 5. Rewriting the same value, or writing any other value, gives no pulse.
- R10: A 1-byte write of 0x10 to offset 0x10 pulses `resetReq` for one cycle. Any other value or width gives no pulse.
- R11: A 1-byte write to offset 0x11 sets control bit 0 when the value is 0xA1 and clears it when the value is 0xA0. Any other value leaves the control register unchanged.
- R12: A read of any unmapped offset, or of a write-only port, returns 0xFFFFFFFF with `ioRdUnused` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioValid | input | 1 | Access present this cycle |
| ioWrite | input | 1 | 1 = write, 0 = read |
| ioOffset | input | 8 | Byte offset within the window |
| ioSize | input | 3 | Access width in bytes (1, 2 or 4) |
| ioWdata | input | 16 | Write data, low-aligned |
| ioRdata | output | 32 | Read data, combinational while a read is presented |
| ioRdUnused | output | 1 | Read hit nothing at this width |
| pwrBtnEvent | input | 1 | One-cycle power-button event |
| batInfoEvent | input | 1 | One-cycle battery-information-changed event |
| sciLevel | output | 1 | Level-sensitive system control interrupt |
| powerOffReq | output | 1 | One-cycle power-off request |
| resetReq | output | 1 | One-cycle system reset request |
| btnHandled | output | 1 | Software acknowledged the last power-button event |

## Verification
The assertions assume that each event input is low while reset is applied, so the checks that follow an event do not see a stale pre-reset value. They also assume that `ioSize` is one of 1, 2 or 4. The stimulus drives events and accesses only on falling edges after reset is released, and every access uses one of those three widths. Some wrong widths, such as 4 bytes on a 16-bit register, are chosen on purpose to test rejection. The timer is checked with a small clock ratio and a short counter, so overflow and wrap occur within a short run.

// File: rtl/pm_fixed_regs_pkg.sv
`timescale 1ns/1ps
package pm_fixed_regs_pkg;
  localparam int OFS_W  = 8;
  localparam int GPE_W  = 8;
  localparam int PM1_W  = 16;

  localparam logic [OFS_W-1:0] OFS_PM1_STS = 8'h00;
  localparam logic [OFS_W-1:0] OFS_PM1_EN  = 8'h02;
  localparam logic [OFS_W-1:0] OFS_PM1_CTL = 8'h04;
  localparam logic [OFS_W-1:0] OFS_TMR     = 8'h08;
  localparam logic [OFS_W-1:0] OFS_RST     = 8'h10;
  localparam logic [OFS_W-1:0] OFS_MODE    = 8'h11;
  localparam logic [OFS_W-1:0] OFS_GPE_STS = 8'h20;
  localparam logic [OFS_W-1:0] OFS_GPE_EN  = 8'h21;

  localparam logic [7:0] RST_MAGIC = 8'h10;
  localparam logic [7:0] MODE_ON   = 8'hA1;
  localparam logic [7:0] MODE_OFF  = 8'hA0;

  localparam int          SLP_LSB   = 10;
  localparam int          SLP_W     = 3;
  localparam logic [2:0]  SLP_OFF   = 3'd5;
  localparam int          BIT_MODE  = 0;
  localparam int          BIT_TMR   = 0;
  localparam int          BIT_BTN   = 8;
  localparam int          BIT_BAT   = 0;
  localparam logic [PM1_W-1:0] PM1_MASK = 16'h0101;

  typedef enum logic [2:0] {
    RD_NONE, RD_PM1_STS, RD_PM1_EN, RD_PM1_CTL, RD_TMR, RD_GPE_STS, RD_GPE_EN
  } rdSel_e;

  typedef struct packed {
    logic wrPm1Sts;
    logic wrPm1En;
    logic wrPm1Ctl;
    logic wrGpeSts;
    logic wrGpeEn;
    logic modeOn;
    logic modeOff;
    logic rstHit;
  } pmStrobe_t;
endpackage

// File: rtl/pm_decode.sv
`timescale 1ns/1ps
module pm_decode
  import pm_fixed_regs_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             ioValid,
  input  logic             ioWrite,
  input  logic [OFS_W-1:0] ioOffset,
  input  logic [2:0]       ioSize,
  input  logic [7:0]       wrByte,
  output pmStrobe_t        strobe,
  output rdSel_e           rdSel,
  output logic             rdMiss
);
  logic isWr, isRd, sz1, sz2, sz4;

  always_comb begin
    isWr   = ioValid && ioWrite;
    isRd   = ioValid && !ioWrite;
    sz1    = (ioSize == 3'd1);
    sz2    = (ioSize == 3'd2);
    sz4    = (ioSize == 3'd4);
    strobe = '0;
    rdSel  = RD_NONE;
    case (ioOffset)
      OFS_PM1_STS: if (sz2) begin strobe.wrPm1Sts = isWr; rdSel = RD_PM1_STS; end
      OFS_PM1_EN:  if (sz2) begin strobe.wrPm1En  = isWr; rdSel = RD_PM1_EN;  end
      OFS_PM1_CTL: if (sz2) begin strobe.wrPm1Ctl = isWr; rdSel = RD_PM1_CTL; end
      OFS_TMR:     if (sz4) rdSel = RD_TMR;
      OFS_GPE_STS: if (sz1) begin strobe.wrGpeSts = isWr; rdSel = RD_GPE_STS; end
      OFS_GPE_EN:  if (sz1) begin strobe.wrGpeEn  = isWr; rdSel = RD_GPE_EN;  end
      OFS_RST:     if (sz1) strobe.rstHit = isWr && (wrByte == RST_MAGIC);
      OFS_MODE:    if (sz1) begin
                     strobe.modeOn  = isWr && (wrByte == MODE_ON);
                     strobe.modeOff = isWr && (wrByte == MODE_OFF);
                   end
      default: ;
    endcase
    rdMiss = isRd && (rdSel == RD_NONE);
  end

  // R3: at most one register is written per access
  a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe));
  // R12: no write strobe ever fires on a read cycle
  a_r12_read_no_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (ioValid && !ioWrite) |-> (strobe == '0));
endmodule

// File: rtl/pm_timer.sv
`timescale 1ns/1ps
module pm_timer #(
  parameter int CLK_HZ    = 50_000_000,
  parameter int TMR_HZ    = 3_579_545,
  parameter int TMR_WIDTH = 24
) (
  input  logic                 clk,
  input  logic                 rstN,
  output logic [TMR_WIDTH-1:0] count,
  output logic                 msbFlip
);
  localparam int ACC_W = $clog2(CLK_HZ + TMR_HZ) + 1;
  localparam logic [ACC_W-1:0] STEP  = ACC_W'(TMR_HZ);
  localparam logic [ACC_W-1:0] LIMIT = ACC_W'(CLK_HZ);

  logic [ACC_W-1:0]     phase, phaseSum;
  logic                 tick;
  logic [TMR_WIDTH-1:0] countNext;

  always_comb begin
    phaseSum  = phase + STEP;
    tick      = (phaseSum >= LIMIT);
    countNext = count + 1'b1;
    msbFlip   = tick && (countNext[TMR_WIDTH-1] != count[TMR_WIDTH-1]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= '0;
      count <= '0;
    end else if (tick) begin
      phase <= phaseSum - LIMIT;
      count <= countNext;
    end else begin
      phase <= phaseSum;
    end
  end

  // R2: a tick advances the count by exactly one, otherwise it holds
  a_r2_tick_step: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(tick) |-> count == TMR_WIDTH'($past(count) + 1'b1));
  a_r2_hold: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && !$past(tick) |-> $stable(count));
endmodule

// File: rtl/pm_regs.sv
`timescale 1ns/1ps
module pm_regs
  import pm_fixed_regs_pkg::*;
#(
  parameter int TMR_WIDTH = 24
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  pmStrobe_t            strobe,
  input  rdSel_e               rdSel,
  input  logic [PM1_W-1:0]     wdata,
  input  logic                 pwrBtnEvent,
  input  logic                 batInfoEvent,
  input  logic [TMR_WIDTH-1:0] tmrCount,
  input  logic                 tmrFlip,
  output logic [31:0]          rdData,
  output logic                 sciLevel,
  output logic                 powerOffReq,
  output logic                 resetReq,
  output logic                 btnHandled
);
  logic [PM1_W-1:0] pm1Sts, pm1En, pm1Ctl, pm1StsNext;
  logic [GPE_W-1:0] gpeSts, gpeEn, gpeStsNext;
  logic [SLP_W-1:0] sleepState, slpNew;
  logic             pm1Pend, gpePend;

  always_comb begin
    pm1StsNext = pm1Sts;
    if (strobe.wrPm1Sts) pm1StsNext = pm1StsNext & ~wdata;
    if (tmrFlip)         pm1StsNext[BIT_TMR] = 1'b1;
    if (pwrBtnEvent)     pm1StsNext[BIT_BTN] = 1'b1;
    pm1StsNext = pm1StsNext & PM1_MASK;

    gpeStsNext = gpeSts;
    if (strobe.wrGpeSts) gpeStsNext = gpeStsNext & ~wdata[GPE_W-1:0];
    if (batInfoEvent)    gpeStsNext[BIT_BAT] = 1'b1;

    slpNew  = wdata[SLP_LSB +: SLP_W];
    pm1Pend = |(pm1Sts & pm1En);
    gpePend = |(gpeSts & gpeEn);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pm1Sts      <= '0;
      pm1En       <= '0;
      pm1Ctl      <= '0;
      gpeSts      <= '0;
      gpeEn       <= '0;
      sleepState  <= '0;
      sciLevel    <= 1'b0;
      powerOffReq <= 1'b0;
      resetReq    <= 1'b0;
      btnHandled  <= 1'b0;
    end else begin
      pm1Sts      <= pm1StsNext;
      gpeSts      <= gpeStsNext;
      sciLevel    <= pm1Pend | gpePend;
      resetReq    <= strobe.rstHit;
      powerOffReq <= 1'b0;
      if (strobe.wrPm1En) pm1En <= wdata & PM1_MASK;
      if (strobe.wrGpeEn) gpeEn <= wdata[GPE_W-1:0];
      if (strobe.wrPm1Ctl) begin
        pm1Ctl <= wdata;
        if (slpNew != sleepState) begin
          sleepState  <= slpNew;
          powerOffReq <= (slpNew == SLP_OFF);
        end
      end
      if (strobe.modeOn)  pm1Ctl[BIT_MODE] <= 1'b1;
      if (strobe.modeOff) pm1Ctl[BIT_MODE] <= 1'b0;
      if (pwrBtnEvent) btnHandled <= 1'b0;
      else if (strobe.wrPm1Sts && wdata[BIT_BTN]) btnHandled <= 1'b1;
    end
  end

  always_comb begin
    case (rdSel)
      RD_PM1_STS: rdData = 32'(pm1Sts);
      RD_PM1_EN:  rdData = 32'(pm1En);
      RD_PM1_CTL: rdData = 32'(pm1Ctl);
      RD_TMR:     rdData = 32'(tmrCount);
      RD_GPE_STS: rdData = 32'(gpeSts);
      RD_GPE_EN:  rdData = 32'(gpeEn);
      default:    rdData = 32'hFFFF_FFFF;
    endcase
  end

  // R9: a power-off pulse only ever comes with sleep type 5 in control
  a_r9_off_only_s5: assert property (@(posedge clk) disable iff (!rstN)
    powerOffReq |-> pm1Ctl[SLP_LSB +: SLP_W] == SLP_OFF);
  // R6: the handled flag rises only after a status write carrying bit 8
  a_r6_handled_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(btnHandled) |-> $past(strobe.wrPm1Sts && wdata[BIT_BTN]));
  // R7: a pending term asserts the interrupt on the next clock
  a_r7_sci_pm1: assert property (@(posedge clk) disable iff (!rstN)
    pm1Pend |=> sciLevel);
  a_r7_sci_gpe: assert property (@(posedge clk) disable iff (!rstN)
    gpePend |=> sciLevel);
  // R8 and R4: a battery event leaves its status bit set even against a clear
  a_r8_bat_sets: assert property (@(posedge clk) disable iff (!rstN)
    batInfoEvent |=> gpeSts[BIT_BAT]);
  // R5: a timer MSB toggle sets the overflow status bit
  a_r5_tmr_sets: assert property (@(posedge clk) disable iff (!rstN)
    tmrFlip |=> pm1Sts[BIT_TMR]);
endmodule

// File: rtl/pm_fixed_regs.sv
`timescale 1ns/1ps
module pm_fixed_regs
  import pm_fixed_regs_pkg::*;
#(
  parameter int CLK_HZ    = 50_000_000,
  parameter int TMR_HZ    = 3_579_545,
  parameter int TMR_WIDTH = 24
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        ioValid,
  input  logic        ioWrite,
  input  logic [7:0]  ioOffset,
  input  logic [2:0]  ioSize,
  input  logic [15:0] ioWdata,
  output logic [31:0] ioRdata,
  output logic        ioRdUnused,
  input  logic        pwrBtnEvent,
  input  logic        batInfoEvent,
  output logic        sciLevel,
  output logic        powerOffReq,
  output logic        resetReq,
  output logic        btnHandled
);
  pmStrobe_t            strobe;
  rdSel_e               rdSel;
  logic [TMR_WIDTH-1:0] tmrCount;
  logic                 tmrFlip;

  pm_decode decode_i (
    .clk(clk), .rstN(rstN), .ioValid(ioValid), .ioWrite(ioWrite),
    .ioOffset(ioOffset), .ioSize(ioSize), .wrByte(ioWdata[7:0]),
    .strobe(strobe), .rdSel(rdSel), .rdMiss(ioRdUnused)
  );

  pm_timer #(.CLK_HZ(CLK_HZ), .TMR_HZ(TMR_HZ), .TMR_WIDTH(TMR_WIDTH)) timer_i (
    .clk(clk), .rstN(rstN), .count(tmrCount), .msbFlip(tmrFlip)
  );

  pm_regs #(.TMR_WIDTH(TMR_WIDTH)) regs_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rdSel(rdSel), .wdata(ioWdata),
    .pwrBtnEvent(pwrBtnEvent), .batInfoEvent(batInfoEvent),
    .tmrCount(tmrCount), .tmrFlip(tmrFlip), .rdData(ioRdata),
    .sciLevel(sciLevel), .powerOffReq(powerOffReq), .resetReq(resetReq),
    .btnHandled(btnHandled)
  );
endmodule

// File: tb/pm_fixed_regs_tb_top.sv
`timescale 1ns/1ps
module pm_fixed_regs_tb_top;
  localparam int TW = 6;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ioValid = 1'b0, ioWrite = 1'b0;
  logic [7:0]  ioOffset = '0;
  logic [2:0]  ioSize = 3'd1;
  logic [15:0] ioWdata = '0;
  logic [31:0] ioRdata;
  logic        ioRdUnused;
  logic        pwrBtnEvent = 1'b0, batInfoEvent = 1'b0;
  logic        sciLevel, powerOffReq, resetReq, btnHandled;

  int  nChk = 0, nBad = 0;
  bit  done = 0;

  always #10 clk = ~clk;

  pm_fixed_regs #(.CLK_HZ(4), .TMR_HZ(1), .TMR_WIDTH(TW)) dut_i (
    .clk(clk), .rstN(rstN), .ioValid(ioValid), .ioWrite(ioWrite),
    .ioOffset(ioOffset), .ioSize(ioSize), .ioWdata(ioWdata),
    .ioRdata(ioRdata), .ioRdUnused(ioRdUnused),
    .pwrBtnEvent(pwrBtnEvent), .batInfoEvent(batInfoEvent),
    .sciLevel(sciLevel), .powerOffReq(powerOffReq), .resetReq(resetReq),
    .btnHandled(btnHandled)
  );

  // {tag[3:0], isWrite, offset[7:0], size[2:0], data[31:0], expect[31:0]}
  localparam int NV = 16;
  localparam logic [79:0] VEC [NV] = '{
    {4'd4,  1'b1, 8'h02, 3'd2, 32'h0101, 32'h0},         // R4 enable write
    {4'd4,  1'b0, 8'h02, 3'd2, 32'h0,    32'h0101},      // R4 enable readback
    {4'd3,  1'b0, 8'h02, 3'd1, 32'h0,    32'hFFFF_FFFF}, // R3 wrong width read
    {4'd3,  1'b1, 8'h02, 3'd4, 32'hFFFF, 32'h0},         // R3 wrong width write
    {4'd3,  1'b0, 8'h02, 3'd2, 32'h0,    32'h0101},      // R3 write was ignored
    {4'd4,  1'b1, 8'h21, 3'd1, 32'h03,   32'h0},         // R4 gpe enable write
    {4'd4,  1'b0, 8'h21, 3'd1, 32'h0,    32'h03},        // R4 gpe enable read
    {4'd3,  1'b0, 8'h20, 3'd2, 32'h0,    32'hFFFF_FFFF}, // R3 gpe 2-byte read
    {4'd11, 1'b1, 8'h11, 3'd1, 32'hA1,   32'h0},         // R11 mode on
    {4'd11, 1'b0, 8'h04, 3'd2, 32'h0,    32'h0001},      // R11 bit 0 set
    {4'd11, 1'b1, 8'h11, 3'd1, 32'h55,   32'h0},         // R11 other byte
    {4'd11, 1'b0, 8'h04, 3'd2, 32'h0,    32'h0001},      // R11 unchanged
    {4'd11, 1'b1, 8'h11, 3'd1, 32'hA0,   32'h0},         // R11 mode off
    {4'd11, 1'b0, 8'h04, 3'd2, 32'h0,    32'h0000},      // R11 bit 0 clear
    {4'd12, 1'b0, 8'h30, 3'd4, 32'h0,    32'hFFFF_FFFF}, // R12 unmapped
    {4'd2,  1'b0, 8'h08, 3'd2, 32'h0,    32'hFFFF_FFFF}  // R2 timer 2-byte
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] ofs, input logic [2:0] sz, input logic [15:0] d);
    @(negedge clk);
    ioValid = 1'b1; ioWrite = 1'b1; ioOffset = ofs; ioSize = sz; ioWdata = d;
    @(negedge clk);
    ioValid = 1'b0; ioWrite = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] ofs, input logic [2:0] sz,
                         output logic [31:0] d, output logic miss);
    @(negedge clk);
    ioValid = 1'b1; ioWrite = 1'b0; ioOffset = ofs; ioSize = sz;
    #2;
    d = ioRdata; miss = ioRdUnused;
    ioValid = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, rd2;
    logic        miss;
    bit          seen;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    busRead(8'h00, 3'd2, rd, miss); chk("R1 pm1 sts", rd, 32'h0);
    busRead(8'h02, 3'd2, rd, miss); chk("R1 pm1 en", rd, 32'h0);
    busRead(8'h04, 3'd2, rd, miss); chk("R1 ctl", rd, 32'h0);
    busRead(8'h20, 3'd1, rd, miss); chk("R1 gpe sts", rd, 32'h0);
    busRead(8'h21, 3'd1, rd, miss); chk("R1 gpe en", rd, 32'h0);
    chk("R1 outputs", {28'h0, sciLevel, powerOffReq, resetReq, btnHandled}, 32'h0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][75]) busWrite(VEC[i][74:67], VEC[i][66:64], VEC[i][47:32]);
      else begin
        busRead(VEC[i][74:67], VEC[i][66:64], rd, miss);
        chk($sformatf("R%0d vector %0d", VEC[i][79:76], i), rd, VEC[i][31:0]);
        if (VEC[i][31:0] == 32'hFFFF_FFFF)
          chk($sformatf("R%0d vector %0d unused", VEC[i][79:76], i), {31'h0, miss}, 32'h1);
      end
    end
    busRead(8'h10, 3'd1, rd, miss);
    chk("R12 write-only port read", {rd[30:0], miss}, {31'h7FFF_FFFF, 1'b1});

    busWrite(8'h02, 3'd2, 16'h0000);

    // R2 timer rate and width
    busRead(8'h08, 3'd4, rd, miss);
    repeat (39) @(negedge clk);
    busRead(8'h08, 3'd4, rd2, miss);
    chk("R2 timer delta", 32'((rd2 - rd) & 32'h3F), 32'd10);
    chk("R2 upper zero", rd2 >> TW, 32'h0);

    // R5 overflow status
    seen = 0;
    for (int k = 0; k < 200 && !seen; k++) begin
      busRead(8'h00, 3'd2, rd, miss);
      seen = rd[0];
    end
    chk("R5 overflow seen", {31'h0, seen}, 32'h1);
    busWrite(8'h00, 3'd2, 16'h0001);
    busRead(8'h00, 3'd2, rd, miss); chk("R5 cleared by W1C", {31'h0, rd[0]}, 32'h0);
    repeat (130) @(negedge clk);
    busRead(8'h00, 3'd2, rd, miss); chk("R5 set after next toggle", {31'h0, rd[0]}, 32'h1);

    // R8 and R7 battery event and interrupt lag (gpe enable bit 0 is set)
    @(negedge clk); batInfoEvent = 1'b1;
    @(negedge clk); batInfoEvent = 1'b0;
    chk("R7 sci lags one clock", {31'h0, sciLevel}, 32'h0);
    @(negedge clk);
    chk("R7 sci from gpe", {31'h0, sciLevel}, 32'h1);
    busRead(8'h20, 3'd1, rd, miss); chk("R8 gpe bit 0", rd, 32'h01);

    // R4 zero write leaves status; event beats a simultaneous clear
    busWrite(8'h20, 3'd1, 16'h00);
    busRead(8'h20, 3'd1, rd, miss); chk("R4 zero write no clear", rd, 32'h01);
    @(negedge clk);
    ioValid = 1'b1; ioWrite = 1'b1; ioOffset = 8'h20; ioSize = 3'd1; ioWdata = 16'h01;
    batInfoEvent = 1'b1;
    @(negedge clk);
    ioValid = 1'b0; ioWrite = 1'b0; batInfoEvent = 1'b0;
    busRead(8'h20, 3'd1, rd, miss); chk("R4 event wins", rd, 32'h01);

    // R6 power button and R7 OR of two terms
    busWrite(8'h02, 3'd2, 16'h0100);
    @(negedge clk); pwrBtnEvent = 1'b1;
    @(negedge clk); pwrBtnEvent = 1'b0;
    busRead(8'h00, 3'd2, rd, miss); chk("R6 btn status", rd & 32'h100, 32'h100);
    busWrite(8'h20, 3'd1, 16'h01);
    @(negedge clk);
    chk("R7 held by pm1 term", {31'h0, sciLevel}, 32'h1);
    busWrite(8'h00, 3'd2, 16'h0100);
    chk("R6 handled set", {31'h0, btnHandled}, 32'h1);
    @(negedge clk);
    chk("R7 drops when both clear", {31'h0, sciLevel}, 32'h0);
    busWrite(8'h00, 3'd2, 16'h0000);
    chk("R6 handled sticky", {31'h0, btnHandled}, 32'h1);
    @(negedge clk); pwrBtnEvent = 1'b1;
    @(negedge clk); pwrBtnEvent = 1'b0;
    chk("R6 new event clears handled", {31'h0, btnHandled}, 32'h0);

    // R9 sleep type
    busWrite(8'h04, 3'd2, 16'h1400);
    chk("R9 power off pulse", {31'h0, powerOffReq}, 32'h1);
    @(negedge clk);
    chk("R9 pulse one cycle", {31'h0, powerOffReq}, 32'h0);
    busWrite(8'h04, 3'd2, 16'h1400);
    chk("R9 same value no pulse", {31'h0, powerOffReq}, 32'h0);
    busWrite(8'h04, 3'd2, 16'h0C00);
    chk("R9 type 3 no pulse", {31'h0, powerOffReq}, 32'h0);
    busWrite(8'h04, 3'd2, 16'h0000);
    chk("R9 type 0 no pulse", {31'h0, powerOffReq}, 32'h0);
    busWrite(8'h04, 3'd2, 16'h1400);
    chk("R9 pulse again", {31'h0, powerOffReq}, 32'h1);

    // R10 reset register
    busWrite(8'h10, 3'd1, 16'h10);
    chk("R10 reset pulse", {31'h0, resetReq}, 32'h1);
    @(negedge clk);
    chk("R10 pulse one cycle", {31'h0, resetReq}, 32'h0);
    busWrite(8'h10, 3'd1, 16'h11);
    chk("R10 other value", {31'h0, resetReq}, 32'h0);
    busWrite(8'h10, 3'd2, 16'h10);
    chk("R10 wrong width", {31'h0, resetReq}, 32'h0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule